// File: doc/BRIEF.md
# Serial register-access slave for a real-time clock

This block is the serial-port front end of a real-time-clock register space. An external master runs an SPI-style bus: chip select is active high, words are 8 bits, and the clock phase is such that the slave samples MOSI on the falling SCLK edge and changes MISO on the rising edge. SCLK runs at up to 2 MHz. The block oversamples SCLK, chip select and MOSI with the fast system clock. It turns each transaction into byte-wide accesses on a simple parallel register bus.

The first byte of a transaction is a command. Its top bit selects write (1) or read (0), and its low seven bits give the starting register. Each later byte is written to, or read from, the current register, and the address then steps by one. This lets a single transaction move a whole bank. The block decodes the space into five banks: time/date, two alarm banks, a three-byte control group, and a general-purpose RAM window. It tags each strobe with a bank code. The timekeeping, alarm and interrupt logic behind the bus lies outside the block. The block enforces the write-protect bit of the control register, and it forces the unused bits of the control and status registers to zero.

Top module: `rtc_spi_regif`

## Requirements
- R1: The first byte after chip select rises is a command. If bit 7 is 1, later bytes are writes. If bit 7 is 0, the register named by bits 6:0 is read at once, and one more read strobe is issued as each data byte completes. `reg_we_o` and `reg_re_o` are never high together.
- R2: Words are 8 bits, MSB first. MOSI is captured on falling SCLK. MISO changes only after rising SCLK and shows bit 7 of the read byte from the first rising edge of that byte.
- R3: The bank codes on `reg_bank_o` are: 0x00–0x06 give 1 (time/date), 0x07–0x0A give 2 (alarm 0), 0x0B–0x0E give 3 (alarm 1), 0x0F–0x11 give 4 (control 0x0F, status 0x10, config 0x11), and 0x20–0x7F give 5 (RAM).
- R4: The register address steps by one after each data byte and wraps from 0x7F to 0x00.
- R5: An address outside every bank produces no strobe. A read of such an address returns 0x00 on MISO.
- R6: Bit 6 of the control register (0x0F) is write protect. The block tracks it from its own control writes and clears it at reset. While it is set, writes to any address other than 0x0F produce no strobe, including later bytes of the burst that set it.
- R7: Control bits 5:3 and status bits 7:2 are forced to zero in write data and in read data.
- R8: If chip select falls in the middle of a byte, the partial byte is discarded. The next transaction starts again with a command byte.
- R9: While chip select is low, `spi_miso_oe_o` and `spi_miso_o` are 0.
- R10: After reset no strobe is active, MISO is not driven, and write protect is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_cs_i | input | 1 | Chip select, active high |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| spi_miso_oe_o | output | 1 | Output enable for MISO |
| reg_addr_o | output | 7 | Register address of the current strobe |
| reg_bank_o | output | 3 | Bank code of the current strobe |
| reg_wdata_o | output | 8 | Write data, with fixed-zero bits cleared |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe; `reg_rdata_i` is taken in the same cycle |
| reg_rdata_i | input | 8 | Read data from the register banks |

## Verification
The hardest case to reach is write protect taking effect inside a single burst. A control write that sets bit 6 must block the status-register write carried in the same transaction and the config-register write that follows it. The bench reaches it with a three-byte burst starting at 0x0F, then a RAM write that must stay blocked until a second control write clears the bit. A transaction cut by chip select after three bits of a data byte checks that a partial byte never reaches the bus. A burst that starts at 0x7E checks the wrap to 0x00.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  typedef enum logic [2:0] {
    BANK_NONE = 3'd0,
    BANK_TIME = 3'd1,
    BANK_ALM0 = 3'd2,
    BANK_ALM1 = 3'd3,
    BANK_CTRL = 3'd4,
    BANK_RAM  = 3'd5
  } bank_e;

  localparam int ADDR_W = 7;
  localparam int WORD_W = 8;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rtc_spi_decode.sv
module rtc_spi_decode
  import rtc_spi_pkg::*;
#(
  parameter int TIME_LEN = 7,
  parameter int ALM_LEN  = 4,
  parameter int NUM_ALM  = 2,
  parameter int CTRL_LEN = 3,
  parameter int RAM_BASE = 32,
  parameter int RAM_LEN  = 96
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bank_e             bank_o
);
  localparam int ALM_BASE  = TIME_LEN;
  localparam int CTRL_BASE = ALM_BASE + NUM_ALM * ALM_LEN;
  localparam int RAM_END   = RAM_BASE + RAM_LEN;

  always_comb begin
    int a;
    a = int'(addr_i);
    bank_o = BANK_NONE;
    if (a < TIME_LEN) bank_o = BANK_TIME;
    for (int i = 0; i < NUM_ALM; i++) begin
      if (a >= ALM_BASE + i * ALM_LEN && a < ALM_BASE + (i + 1) * ALM_LEN)
        bank_o = bank_e'(BANK_ALM0 + 3'(i));
    end
    if (a >= CTRL_BASE && a < CTRL_BASE + CTRL_LEN) bank_o = BANK_CTRL;
    if (a >= RAM_BASE && a < RAM_END) bank_o = BANK_RAM;
  end
endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic [WORD_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              miso_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      miso_o     <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!active_i) begin
        cnt_q  <= '0;  // partial byte dropped
        tx_q   <= '0;
        miso_o <= 1'b0;
      end else begin
        if (fall_i) begin
          rx_q  <= {rx_q[WORD_W-2:0], mosi_i};
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {rx_q[WORD_W-2:0], mosi_i};
          end
        end
        if (load_i) begin
          tx_q <= load_data_i;
        end else if (rise_i) begin
          miso_o <= tx_q[WORD_W-1];
          tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);  // R2
  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !miso_o);  // R9
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
  import rtc_spi_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   TIME_LEN    = 7,
  parameter int   ALM_LEN     = 4,
  parameter int   NUM_ALM     = 2,
  parameter int   CTRL_LEN    = 3,
  parameter int   RAM_BASE    = 32,
  parameter int   RAM_LEN     = 96,
  parameter int   WP_BIT      = 6,
  parameter logic WP_RST      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [2:0]        reg_bank_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(TIME_LEN + NUM_ALM * ALM_LEN);
  localparam logic [ADDR_W-1:0] STAT_ADDR = CTRL_ADDR + 1'b1;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 8'hC7;
  localparam logic [WORD_W-1:0] STAT_KEEP = 8'h03;

  function automatic logic [WORD_W-1:0] keep_bits(input logic [ADDR_W-1:0] a,
                                                   input logic [WORD_W-1:0] d);
    if (a == CTRL_ADDR) return d & CTRL_KEEP;
    if (a == STAT_ADDR) return d & STAT_KEEP;
    return d;
  endfunction

  logic sclk_s, cs_s, mosi_s, sclk_q;
  logic rise, fall;

  rtc_spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_sclk_i, spi_cs_i, spi_mosi_i}),
    .q_o   ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end
  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  logic [WORD_W-1:0] byte_val, ld_data;
  logic              byte_vld, load_q;

  rtc_spi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (cs_s),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .load_i     (load_q),
    .load_data_i(ld_data),
    .byte_o     (byte_val),
    .byte_vld_o (byte_vld),
    .miso_o     (spi_miso_o)
  );

  logic              first_q, wr_q, wp_q, we_q, re_q;
  logic [ADDR_W-1:0] addr_q, sa_q, acc_addr;
  logic [WORD_W-1:0] wd_q;
  bank_e             bank_q, acc_bank;
  logic              wr_now, wr_ok, take, we_n, re_n;

  assign take     = byte_vld & cs_s;
  assign wr_now   = first_q ? byte_val[WORD_W-1] : wr_q;
  assign acc_addr = first_q ? byte_val[ADDR_W-1:0] : (wr_q ? addr_q : addr_q + 1'b1);

  rtc_spi_decode #(
    .TIME_LEN(TIME_LEN), .ALM_LEN(ALM_LEN), .NUM_ALM(NUM_ALM),
    .CTRL_LEN(CTRL_LEN), .RAM_BASE(RAM_BASE), .RAM_LEN(RAM_LEN)
  ) u_dec (
    .addr_i(acc_addr),
    .bank_o(acc_bank)
  );

  assign wr_ok = !wp_q || (acc_addr == CTRL_ADDR);
  assign we_n  = take & !first_q & wr_q & (acc_bank != BANK_NONE) & wr_ok;
  assign re_n  = take & !wr_now & (acc_bank != BANK_NONE);
  assign ld_data = re_q ? keep_bits(sa_q, reg_rdata_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      wr_q    <= 1'b0;
      wp_q    <= WP_RST;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      load_q  <= 1'b0;
      addr_q  <= '0;
      sa_q    <= '0;
      wd_q    <= '0;
      bank_q  <= BANK_NONE;
    end else begin
      we_q   <= we_n;
      re_q   <= re_n;
      load_q <= take & !wr_now;
      if (take) begin
        sa_q   <= acc_addr;
        bank_q <= acc_bank;
        wd_q   <= keep_bits(acc_addr, byte_val);
      end
      if (we_n && acc_addr == CTRL_ADDR) wp_q <= byte_val[WP_BIT];
      if (!cs_s) begin
        first_q <= 1'b1;
      end else if (byte_vld) begin
        first_q <= 1'b0;
        if (first_q) begin
          wr_q   <= byte_val[WORD_W-1];
          addr_q <= byte_val[ADDR_W-1:0];
        end else begin
          addr_q <= addr_q + 1'b1;  // wraps 0x7F -> 0x00
        end
      end
    end
  end

  assign reg_addr_o    = sa_q;
  assign reg_bank_o    = bank_q;
  assign reg_wdata_o   = wd_q;
  assign reg_we_o      = we_q;
  assign reg_re_o      = re_q;
  assign spi_miso_oe_o = cs_s;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));  // R1
  AST_BANK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> (reg_bank_o != 3'(BANK_NONE)));  // R5
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && wp_q) |-> (reg_addr_o == CTRL_ADDR));  // R6
  AST_STAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == STAT_ADDR) |-> (reg_wdata_o[7:2] == 6'd0));  // R7
  AST_CS_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !reg_we_o && !reg_re_o);  // R8
endmodule

// File: tb/rtc_spi_regif_test.sv
`timescale 1ns/1ps
module rtc_spi_regif_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, we, re;
  logic [6:0] addr;
  logic [2:0] bank;
  logic [7:0] wdata, rdata;

  always #2.5 clk = ~clk;

  rtc_spi_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_cs_i(cs),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .reg_addr_o(addr), .reg_bank_o(bank), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  typedef struct {
    bit       wr;
    bit [6:0] a;
    bit [2:0] b;
    bit [7:0] d;
    string    req;
  } ev_t;
  ev_t q[$];

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];
  logic [7:0] buf_d   [8];
  bit exp_wp = 1'b0;
  bit done = 1'b0;
  int n_run = 0, n_fail = 0;

  // bench-side register banks
  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [2:0] bank_of(input int a);
    if (a <= 6) return 3'd1;
    if (a <= 10) return 3'd2;
    if (a <= 14) return 3'd3;
    if (a <= 17) return 3'd4;
    if (a >= 32) return 3'd5;
    return 3'd0;
  endfunction

  function automatic bit [7:0] fix(input int a, input bit [7:0] d);
    if (a == 15) return d & 8'hC7;
    if (a == 16) return d & 8'h03;
    return d;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (we || re)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected strobe", int'(addr), 0);
      end else begin
        ev_t e;
        e = q.pop_front();
        chk(we == e.wr && addr == e.a && bank == e.b && (!e.wr || wdata == e.d),
            e.req, int'({we, bank, addr, wdata}), int'({e.wr, e.b, e.a, e.d}));
      end
    end
  end

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      sclk = 1'b1;
      mosi = tx[i];
      #250;
      rx[i] = miso;
      sclk = 1'b0;
      #250;
    end
  endtask

  task automatic txn(input bit [7:0] cmd, input int n, input string req);
    logic [7:0] rx;
    int a;
    a = int'(cmd[6:0]);
    if (cmd[7]) begin
      for (int i = 0; i < n; i++) begin
        int aa;
        aa = (a + i) % 128;
        if (bank_of(aa) != 0 && (!exp_wp || aa == 15)) begin
          q.push_back('{1'b1, 7'(aa), bank_of(aa), fix(aa, buf_d[i]), req});
          exp_mem[aa] = fix(aa, buf_d[i]);
          if (aa == 15) exp_wp = buf_d[i][6];
        end
      end
    end else begin
      for (int i = 0; i <= n; i++) begin
        int aa;
        aa = (a + i) % 128;
        if (bank_of(aa) != 0) q.push_back('{1'b0, 7'(aa), bank_of(aa), 8'h00, req});
      end
    end
    cs = 1'b1;
    #100;
    spi_bits(cmd, 8, rx);
    for (int i = 0; i < n; i++) begin
      spi_bits(buf_d[i], 8, rx);
      if (!cmd[7]) begin
        int aa;
        logic [7:0] ex;
        aa = (a + i) % 128;
        ex = (bank_of(aa) != 0) ? exp_mem[aa] : 8'h00;
        chk(rx == ex, req, int'(rx), int'(ex));
      end
    end
    #250;
    cs = 1'b0;
    #300;
  endtask

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    for (int i = 0; i < 8; i++) buf_d[i] = 8'h00;
    mem[15] = 8'h38;  exp_mem[15] = 8'h00;  // fixed-zero bits set in storage
    mem[16] = 8'hFF;  exp_mem[16] = 8'h03;
    #42;
    chk(!miso_oe && !we && !re, "R10 outputs in reset", int'({miso_oe, we, re}), 0);
    rst_n = 1'b1;
    #50;
    chk(!miso_oe && !miso, "R10 R9 idle after reset", int'({miso_oe, miso}), 0);

    // R7 read masking of control/status
    txn(8'h0F, 3, "R7 control group read mask");

    // R1 R3 R4 time bank burst write and readback
    buf_d = '{8'h59, 8'h58, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h00};
    txn(8'h80, 7, "R3 R4 time write burst");
    txn(8'h00, 7, "R1 R2 time readback");

    // R3 alarm banks
    buf_d = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h81};
    txn(8'h87, 8, "R3 alarm banks write");
    txn(8'h07, 8, "R3 alarm banks read");

    // R6 write protect engages mid-burst, R7 write masks
    buf_d = '{8'hFF, 8'hFF, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    txn(8'h8F, 3, "R6 R7 control burst sets protect");
    buf_d[0] = 8'h5A;
    txn(8'hA0, 1, "R6 protected RAM write");
    txn(8'h0F, 3, "R6 R7 control readback");
    txn(8'h20, 1, "R6 RAM unchanged under protect");
    buf_d[0] = 8'h00;
    txn(8'h8F, 1, "R6 clear protect");
    buf_d = '{8'h5A, 8'h6B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    txn(8'hA0, 2, "R6 RAM write after clear");
    txn(8'h20, 2, "R6 RAM readback");

    // R4 wrap 0x7F -> 0x00
    buf_d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00};
    txn(8'hFE, 4, "R4 wrap write");
    txn(8'h7E, 4, "R4 wrap read");

    // R5 unimplemented addresses
    buf_d = '{8'hEE, 8'hEE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    txn(8'h92, 2, "R5 unimplemented write");
    txn(8'h12, 2, "R5 unimplemented read");

    // R8 chip select dropped mid-byte
    cs = 1'b1;
    #100;
    spi_bits(8'hA1, 8, rx);
    spi_bits(8'hFF, 3, rx);
    cs = 1'b0;
    #300;
    chk(!miso_oe && !miso, "R9 MISO released after drop", int'({miso_oe, miso}), 0);
    txn(8'h21, 1, "R8 partial byte discarded");

    #200;
    chk(q.size() == 0, "R1 all expected strobes seen", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule